// File: doc/BRIEF.md
# 8080-Style Parallel Bus Master

This block lets a host issue single byte transfers to a display controller over an 8-bit parallel bus with separate read and write strobes. Each transfer carries a flag that selects the data path or the command path. The host presents a request on a valid/ready handshake. The block then runs one complete bus cycle: chip-select, the data/command line, the strobe, the data bus and the bus turnaround. When a read finishes, the captured byte comes back on a response port.

Every timing rule of the bus is given in nanoseconds as a parameter, together with the system clock period. The block converts each rule into a whole number of clocks, rounding up. It then splits the cycle into phases: setup, strobe low, hold and recovery. A counter runs each phase. The bus pins come straight from flops, so no decode glitch can reach a strobe.

The data bus is split into an output, an output enable and an input. The pad ring combines them into one bidirectional bus.

Top module: `pbus8_master`

## Requirements
- R1: While rst_ni is low, and directly after reset, chip-select, both strobes and the output enable are inactive (cs, write and read strobes high, enable low). req_ready_o is 1 and rsp_valid_o is 0.
- R2: A request is accepted only on a clock edge where req_valid_i and req_ready_o are both high. req_ready_o is 0 from the next cycle until the bus cycle has fully ended. Each accepted request produces exactly one strobe pulse: the read strobe when req_read_i=1, the write strobe when req_read_i=0.
- R3: The strobe falls only while chip-select is low. The data/command line (1 = data, 0 = command) takes the value of req_dc_i and is settled at least DC_SETUP_NS (10 ns) before the strobe falls. It stays constant while chip-select is low.
- R4: The write strobe stays low at least WR_LOW_NS (60 ns). It stays high at least WR_HIGH_NS (60 ns) between two write pulses.
- R5: The read strobe stays low at least RD_LOW_NS (120 ns). It stays high at least RD_HIGH_NS (60 ns) between two read pulses.
- R6: From one strobe falling edge to the next, of either kind, at least CYCLE_NS (300 ns) passes.
- R7: On a write, bus_d_o equals the request byte with the enable on. The byte is stable at least WDATA_SETUP_NS (40 ns) before the write strobe rises and at least WDATA_HOLD_NS (7 ns) after it.
- R8: Chip-select stays low at least CS_HOLD_NS (20 ns) after the strobe rises.
- R9: The output enable is never on while the read strobe is low. After a read strobe rises, the enable stays off for at least RELEASE_NS (70 ns).
- R10: The read byte is sampled from bus_d_i on the clock edge that raises the read strobe. That edge comes more than ACCESS_NS (140 ns) after the strobe fell. The byte is returned on rsp_rdata_o with rsp_valid_o high for exactly one cycle, in the cycle where the read strobe has just risen.
- R11: The read and write strobes are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_read_i | input | 1 | 1 = read transfer, 0 = write transfer |
| req_dc_i | input | 1 | 1 = data, 0 = command |
| req_wdata_i | input | DW | Write byte |
| rsp_valid_o | output | 1 | One-cycle pulse with read data |
| rsp_rdata_o | output | DW | Read byte |
| bus_cs_no | output | 1 | Chip-select, active low |
| bus_wr_no | output | 1 | Write strobe, active low |
| bus_rd_no | output | 1 | Read strobe, active low |
| bus_dc_o | output | 1 | Data/command select |
| bus_d_o | output | DW | Data bus, outbound |
| bus_d_oe_o | output | 1 | Data bus output enable |
| bus_d_i | input | DW | Data bus, inbound |

## Verification
The bench builds the block with its default parameters: a 4 ns clock and the nanosecond limits listed above. This gives 3 setup clocks, 15 write-low clocks, 36 read-low clocks, 5 hold clocks, and recovery gaps of 52 clocks after a write and 31 after a read. At these values the read sample edge lands only 2 ns past the point where the modelled target starts driving valid data, so one clock less of read-low returns a wrong byte. The recovery gap sets the write-to-write spacing and the read-to-write spacing. Directed pairs of every order, plus random traffic, measure each pulse width, hold and turnaround in clocks against those limits.

// File: rtl/pbus8_pkg.sv
package pbus8_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_LOW,
    PH_HOLD,
    PH_GAP
  } phase_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pbus8_seq.sv
module pbus8_seq
  import pbus8_pkg::*;
#(
  parameter int CLK_NS         = 4,
  parameter int DC_SETUP_NS    = 10,
  parameter int WR_LOW_NS      = 60,
  parameter int WR_HIGH_NS     = 60,
  parameter int RD_LOW_NS      = 120,
  parameter int RD_HIGH_NS     = 60,
  parameter int CYCLE_NS       = 300,
  parameter int WDATA_SETUP_NS = 40,
  parameter int WDATA_HOLD_NS  = 7,
  parameter int ACCESS_NS      = 140,
  parameter int RELEASE_NS     = 70,
  parameter int CS_HOLD_NS     = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic req_read_i,
  output logic req_ready_o,
  output logic cap_o,
  output logic cs_no,
  output logic wr_no,
  output logic rd_no,
  output logic oe_o
);

  localparam int SETUP_C = max2(1, ceil_div(DC_SETUP_NS, CLK_NS));
  localparam int WLOW_C  = max2(1, max2(ceil_div(WR_LOW_NS, CLK_NS),
                                        ceil_div(WDATA_SETUP_NS, CLK_NS)));
  // one extra clock so the sample edge falls strictly after the access time
  localparam int RLOW_C  = max2(ceil_div(RD_LOW_NS, CLK_NS), ceil_div(ACCESS_NS, CLK_NS) + 1);
  localparam int HOLD_C  = max2(1, max2(ceil_div(CS_HOLD_NS, CLK_NS),
                                        ceil_div(WDATA_HOLD_NS, CLK_NS)));
  localparam int CYC_C   = ceil_div(CYCLE_NS, CLK_NS);
  localparam int WGAP_C  = max2(1, max2(CYC_C - WLOW_C - HOLD_C - SETUP_C,
                                        ceil_div(WR_HIGH_NS, CLK_NS) - HOLD_C - SETUP_C));
  localparam int RGAP_C  = max2(1, max2(max2(CYC_C - RLOW_C - HOLD_C - SETUP_C,
                                             ceil_div(RD_HIGH_NS, CLK_NS) - HOLD_C - SETUP_C),
                                        ceil_div(RELEASE_NS, CLK_NS) - HOLD_C));
  localparam int MAX_C   = max2(max2(max2(SETUP_C, HOLD_C), max2(WLOW_C, RLOW_C)),
                                max2(WGAP_C, RGAP_C));
  localparam int CNT_W   = $clog2(MAX_C + 1);

  localparam logic [CNT_W-1:0] L_SETUP = CNT_W'(SETUP_C - 1);
  localparam logic [CNT_W-1:0] L_WLOW  = CNT_W'(WLOW_C - 1);
  localparam logic [CNT_W-1:0] L_RLOW  = CNT_W'(RLOW_C - 1);
  localparam logic [CNT_W-1:0] L_HOLD  = CNT_W'(HOLD_C - 1);
  localparam logic [CNT_W-1:0] L_WGAP  = CNT_W'(WGAP_C - 1);
  localparam logic [CNT_W-1:0] L_RGAP  = CNT_W'(RGAP_C - 1);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rd_q, rd_d;
  logic             cnt_zero, sel_d;

  assign cnt_zero    = (cnt_q == '0);
  assign req_ready_o = (ph_q == PH_IDLE);
  assign cap_o       = (ph_q == PH_LOW) && rd_q && cnt_zero;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    rd_d  = rd_q;
    case (ph_q)
      PH_IDLE: if (req_valid_i) begin
        ph_d  = PH_SETUP;
        cnt_d = L_SETUP;
        rd_d  = req_read_i;
      end
      PH_SETUP: if (cnt_zero) begin
        ph_d  = PH_LOW;
        cnt_d = rd_q ? L_RLOW : L_WLOW;
      end else cnt_d = cnt_q - 1'b1;
      PH_LOW: if (cnt_zero) begin
        ph_d  = PH_HOLD;
        cnt_d = L_HOLD;
      end else cnt_d = cnt_q - 1'b1;
      PH_HOLD: if (cnt_zero) begin
        ph_d  = PH_GAP;
        cnt_d = rd_q ? L_RGAP : L_WGAP;
      end else cnt_d = cnt_q - 1'b1;
      PH_GAP: if (cnt_zero) ph_d = PH_IDLE;
              else cnt_d = cnt_q - 1'b1;
      default: ph_d = PH_IDLE;
    endcase
  end

  assign sel_d = (ph_d == PH_SETUP) || (ph_d == PH_LOW) || (ph_d == PH_HOLD);

  // pins registered from next phase so they change with the phase flops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      rd_q  <= 1'b0;
      cs_no <= 1'b1;
      wr_no <= 1'b1;
      rd_no <= 1'b1;
      oe_o  <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      rd_q  <= rd_d;
      cs_no <= !sel_d;
      wr_no <= !((ph_d == PH_LOW) && !rd_d);
      rd_no <= !((ph_d == PH_LOW) && rd_d);
      oe_o  <= sel_d && !rd_d;
    end
  end

  assert_strobe_in_cs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_no || !rd_no) |-> !cs_no);
  assert_excl_strobe_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!wr_no && !rd_no));
  assert_busy_after_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  assert_cap_ends_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |-> (!rd_no ##1 rd_no));

endmodule

// File: rtl/pbus8_dpath.sv
module pbus8_dpath #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          req_dc_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          cap_i,
  input  logic [DW-1:0] bus_d_i,
  output logic          dc_o,
  output logic [DW-1:0] wdata_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dc_o        <= 1'b0;
      wdata_o     <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      if (accept_i) begin
        dc_o    <= req_dc_i;
        wdata_o <= req_wdata_i;
      end
      rsp_valid_o <= cap_i;
      if (cap_i) rsp_rdata_o <= bus_d_i;
    end
  end

  assert_rsp_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

endmodule

// File: rtl/pbus8_master.sv
module pbus8_master #(
  parameter int DW             = 8,
  parameter int CLK_NS         = 4,
  parameter int DC_SETUP_NS    = 10,
  parameter int WR_LOW_NS      = 60,
  parameter int WR_HIGH_NS     = 60,
  parameter int RD_LOW_NS      = 120,
  parameter int RD_HIGH_NS     = 60,
  parameter int CYCLE_NS       = 300,
  parameter int WDATA_SETUP_NS = 40,
  parameter int WDATA_HOLD_NS  = 7,
  parameter int ACCESS_NS      = 140,
  parameter int RELEASE_NS     = 70,
  parameter int CS_HOLD_NS     = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_read_i,
  input  logic          req_dc_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          bus_cs_no,
  output logic          bus_wr_no,
  output logic          bus_rd_no,
  output logic          bus_dc_o,
  output logic [DW-1:0] bus_d_o,
  output logic          bus_d_oe_o,
  input  logic [DW-1:0] bus_d_i
);

  logic cap;
  logic accept;

  assign accept = req_valid_i && req_ready_o;

  pbus8_seq #(
    .CLK_NS(CLK_NS), .DC_SETUP_NS(DC_SETUP_NS), .WR_LOW_NS(WR_LOW_NS),
    .WR_HIGH_NS(WR_HIGH_NS), .RD_LOW_NS(RD_LOW_NS), .RD_HIGH_NS(RD_HIGH_NS),
    .CYCLE_NS(CYCLE_NS), .WDATA_SETUP_NS(WDATA_SETUP_NS),
    .WDATA_HOLD_NS(WDATA_HOLD_NS), .ACCESS_NS(ACCESS_NS),
    .RELEASE_NS(RELEASE_NS), .CS_HOLD_NS(CS_HOLD_NS)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_read_i  (req_read_i),
    .req_ready_o (req_ready_o),
    .cap_o       (cap),
    .cs_no       (bus_cs_no),
    .wr_no       (bus_wr_no),
    .rd_no       (bus_rd_no),
    .oe_o        (bus_d_oe_o)
  );

  pbus8_dpath #(.DW(DW)) u_dpath (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .req_dc_i    (req_dc_i),
    .req_wdata_i (req_wdata_i),
    .cap_i       (cap),
    .bus_d_i     (bus_d_i),
    .dc_o        (bus_dc_o),
    .wdata_o     (bus_d_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o)
  );

  assert_no_drive_in_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_no |-> !bus_d_oe_o);
  assert_dc_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_cs_no && $past(!bus_cs_no)) |-> $stable(bus_dc_o));
  assert_wdata_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_d_oe_o && $past(bus_d_oe_o)) |-> $stable(bus_d_o));
  assert_rsp_on_rd_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $rose(bus_rd_no));

endmodule

// File: tb/tb_pbus8_master.sv
module tb_pbus8_master;

  localparam int CLK      = 4;
  localparam int T_DCS    = 10;
  localparam int T_WLO    = 60;
  localparam int T_WHI    = 60;
  localparam int T_RLO    = 120;
  localparam int T_RHI    = 60;
  localparam int T_CYC    = 300;
  localparam int T_WDS    = 40;
  localparam int T_WDH    = 7;
  localparam int T_ACC    = 140;
  localparam int T_REL    = 70;
  localparam int T_CSH    = 20;
  localparam int BIG      = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_read = 1'b0, req_dc = 1'b0;
  logic [7:0] req_wdata = 8'h00;
  logic       req_ready, rsp_valid;
  logic [7:0] rsp_rdata;
  logic       cs_n, wr_n, rd_n, dc, oe;
  logic [7:0] d_o;
  logic [7:0] d_i = 8'h00;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pbus8_master dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_read_i(req_read),
    .req_dc_i(req_dc), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .bus_cs_no(cs_n), .bus_wr_no(wr_n), .bus_rd_no(rd_n), .bus_dc_o(dc),
    .bus_d_o(d_o), .bus_d_oe_o(oe), .bus_d_i(d_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] tgt_val(input int idx);
    return 8'(idx * 29 + 60);
  endfunction

  logic [7:0] wexp_d [256];
  logic       wexp_dc[256];
  logic       rexp_dc[256];
  int wq = 0, rq = 0, wseen = 0, rseen = 0, accepts = 0, falls = 0;

  // bus monitor and target model, sampled on falling clock edges
  logic p_cs = 1, p_wr = 1, p_rd = 1, p_oe = 0, p_dc = 0;
  logic [7:0] p_d = 0;
  int wr_lo = 0, rd_lo = 0, s_wr_rise = BIG, s_rd_rise = BIG, s_any_rise = BIG;
  int s_fall = BIG, cs_lo = 0, dc_st = BIG, d_st = 0;
  bit had_wr = 0, had_rd = 0, had_fall = 0, hold_pend = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit wr_f = p_wr && !wr_n;
      automatic bit wr_r = !p_wr && wr_n;
      automatic bit rd_f = p_rd && !rd_n;
      automatic bit rd_r = !p_rd && rd_n;
      automatic bit cs_r = !p_cs && cs_n;
      if (!wr_n && !rd_n) chk(0, "R11 both strobes low", 1, 0);
      if (oe && !rd_n) chk(0, "R9 enable during read", 1, 0);
      if (wr_f || rd_f) begin
        chk(cs_lo >= 1 && !cs_n, "R3 cs before strobe", cs_lo, 1);
        chk(dc_st * CLK >= T_DCS, "R3 dc setup ns", dc_st * CLK, T_DCS);
        if (had_fall) chk(s_fall * CLK >= T_CYC, "R6 cycle ns", s_fall * CLK, T_CYC);
        falls++;
      end
      if (wr_f) begin
        if (had_wr) chk(s_wr_rise * CLK >= T_WHI, "R4 write high ns", s_wr_rise * CLK, T_WHI);
        chk(dc == wexp_dc[wseen], "R3 dc on write", int'(dc), int'(wexp_dc[wseen]));
      end
      if (rd_f) begin
        if (had_rd) chk(s_rd_rise * CLK >= T_RHI, "R5 read high ns", s_rd_rise * CLK, T_RHI);
        chk(dc == rexp_dc[rseen], "R3 dc on read", int'(dc), int'(rexp_dc[rseen]));
      end
      if (wr_r) begin
        chk(wr_lo * CLK >= T_WLO, "R4 write low ns", wr_lo * CLK, T_WLO);
        chk(d_st * CLK >= T_WDS, "R7 data setup ns", d_st * CLK, T_WDS);
        chk(p_d == wexp_d[wseen], "R7 write byte", int'(p_d), int'(wexp_d[wseen]));
        wseen++;
        had_wr = 1;
      end
      if (rd_r) begin
        chk(rd_lo * CLK >= T_RLO, "R5 read low ns", rd_lo * CLK, T_RLO);
        rseen++;
        had_rd = 1;
      end
      if (hold_pend && (!oe || d_o != p_d)) begin
        chk(s_wr_rise * CLK >= T_WDH, "R7 data hold ns", s_wr_rise * CLK, T_WDH);
        hold_pend = 0;
      end
      if (cs_r) chk(s_any_rise * CLK >= T_CSH, "R8 cs hold ns", s_any_rise * CLK, T_CSH);
      if (oe && !p_oe && had_rd)
        chk(s_rd_rise * CLK >= T_REL, "R9 turnaround ns", s_rd_rise * CLK, T_REL);
      if (rsp_valid) chk(rd_r, "R10 response with read rise", int'(rd_r), 1);
      if (wr_r) hold_pend = 1;
      // counter updates
      wr_lo      = wr_f ? 1 : wr_lo + 1;
      rd_lo      = rd_f ? 1 : rd_lo + 1;
      s_wr_rise  = wr_r ? 1 : (s_wr_rise < BIG ? s_wr_rise + 1 : BIG);
      s_rd_rise  = rd_r ? 1 : (s_rd_rise < BIG ? s_rd_rise + 1 : BIG);
      s_any_rise = (wr_r || rd_r) ? 1 : (s_any_rise < BIG ? s_any_rise + 1 : BIG);
      s_fall     = (wr_f || rd_f) ? 1 : (s_fall < BIG ? s_fall + 1 : BIG);
      if (wr_f || rd_f) had_fall = 1;
      cs_lo      = (p_cs && !cs_n) ? 1 : cs_lo + 1;
      dc_st      = (dc != p_dc) ? 1 : (dc_st < BIG ? dc_st + 1 : BIG);
      d_st       = ((oe && !p_oe) || d_o != p_d) ? 1 : d_st + 1;
      // target: valid byte only once the access time has elapsed at this sample
      if (!rd_n) d_i = (2 * rd_lo * CLK - CLK >= 2 * T_ACC) ? tgt_val(rseen) : ~tgt_val(rseen);
      else d_i = 8'h00;
    end
    p_cs = cs_n; p_wr = wr_n; p_rd = rd_n; p_oe = oe; p_dc = dc; p_d = d_o;
  end

  task automatic do_req(input bit rd, input bit dcv, input logic [7:0] data);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_read = rd; req_dc = dcv; req_wdata = data;
    if (!rd) begin wexp_d[wq] = data; wexp_dc[wq] = dcv; wq++; end
    else begin rexp_dc[rq] = dcv; rq++; end
    accepts++;
    @(negedge clk);
    req_valid = 0;
    req_wdata = ~data;
    chk(!req_ready, "R2 busy after accept", int'(req_ready), 0);
    if (rd) begin
      automatic logic [7:0] exp = tgt_val(rq - 1);
      while (!rsp_valid) @(negedge clk);
      chk(rsp_rdata == exp, "R10 read byte", int'(rsp_rdata), int'(exp));
      @(negedge clk);
      chk(!rsp_valid, "R10 single pulse", int'(rsp_valid), 0);
    end
  endtask

  initial begin
    int r;
    r = $urandom(32'h51d3);
    repeat (3) @(negedge clk);
    chk(cs_n && wr_n && rd_n && !oe, "R1 pins in reset", {cs_n, wr_n, rd_n, oe}, 4'b1110);
    chk(req_ready && !rsp_valid, "R1 handshake in reset", {req_ready, rsp_valid}, 2'b10);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n && wr_n && rd_n && !oe && req_ready, "R1 after reset",
        {cs_n, wr_n, rd_n, oe, req_ready}, 5'b11101);
    // directed orderings
    do_req(0, 0, 8'hA5);
    do_req(0, 1, 8'h5A);
    do_req(1, 1, 8'h00);
    do_req(1, 0, 8'h00);
    do_req(0, 1, 8'hFF);
    do_req(1, 1, 8'h00);
    do_req(0, 0, 8'h00);
    // valid held while busy must not add a strobe
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_read = 0; req_dc = 1; req_wdata = 8'h3C;
    wexp_d[wq] = 8'h3C; wexp_dc[wq] = 1; wq++; accepts++;
    @(negedge clk);
    req_wdata = 8'hC3;
    repeat (20) @(negedge clk);
    req_valid = 0;
    chk(falls == accepts, "R2 no extra strobe", falls, accepts);
    // random traffic
    for (int i = 0; i < 40; i++) begin
      automatic bit rd = 1'($urandom);
      do_req(rd, 1'($urandom), 8'($urandom));
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(wseen == wq, "R2 write count", wseen, wq);
    chk(rseen == rq, "R2 read count", rseen, rq);
    chk(falls == accepts, "R2 one strobe per request", falls, accepts);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule